// File: doc/BRIEF.md
# Two-Thread Decode Stage Controller

This block sits between fetch and rename in a small out-of-order core that runs two hardware threads. Fetch hands it groups of up to `W` instruction tokens per thread per cycle. A token carries a PC, the predicted next PC, a flag marking a PC-relative branch, and the branch target already computed from the encoding. Every accepted token goes into that thread's skid buffer. Each cycle the stage forwards up to `W` tokens in total to rename, taken oldest first from the two buffers. The thread with priority fills the lowest output slots, and priority alternates every cycle. Direct branches are treated as always taken.

Each thread runs its own status machine. A stall from rename, issue/execute or commit holds that thread back and moves it to a blocked state. The fetch side keeps filling the buffer until it can no longer take a whole group. When the stall clears, the thread drains what it buffered, oldest first, and reports that it has unblocked once the buffer has run empty. Decode checks the next-PC prediction of every token it sends. At the first wrong one it redirects fetch to the correct PC and throws away everything younger. A squash from commit discards the thread's buffered and incoming work and reports how many tokens were discarded.

On the fetch side the interface is valid/ready per thread. `fe_ready[t]` depends only on the registered buffer occupancy. A group is taken in a cycle where `fe_valid[t]` and `fe_ready[t]` are both high. Fetch holds its group while ready is low. The rename side has no ready signal: the three stall inputs are the back-pressure, and they act in the same cycle they are seen.

Top module: `dec_stage`

## Requirements
- R1: After reset every thread is Idle (code 0), `stage_active` is 0, no output slot is valid, and `fe_ready` is 1 for both threads.
- R2: `fe_ready[t]` is 1 exactly when thread t holds at most DEPTH-W tokens. A group moves only in a cycle with both valid and ready high, and then lanes 0 to `fe_cnt[t]`-1 are enqueued in lane order. When ready is low the group is not taken.
- R3: Each thread's tokens reach rename in the order they were accepted, never in the cycle of acceptance. A thread that is draining after a stall sends buffered tokens before anything newer.
- R4: If any of the three stall bits of thread t is set, no slot carries thread t in that cycle and the thread is Blocked (code 4) in the next cycle. `fe_block[t]` pulses in the cycle of that decision only when the thread was not already Blocked.
- R5: A Blocked or Unblocking thread without a stall becomes Running (code 1) if its buffer will be empty at the end of the cycle, and `fe_unblock[t]` pulses in that cycle. Otherwise it becomes Unblocking (code 5).
- R6: At most W slots are valid per cycle. The priority thread (thread 0 in the first cycle after reset, then alternating every cycle) takes min(W, occupancy) slots from slot 0. The other thread takes the slots that follow, up to W. A thread that is stalled or being squashed by commit takes no slots.
- R7: For each token the expected next PC is the target when the branch flag is set and PC+ISZ otherwise. The token layout is bits [PCW-1:0] PC, [2PCW-1:PCW] predicted next PC, [3PCW-1:2PCW] target, bit 3PCW branch flag. At the first token whose prediction differs, that token is still sent. `redir_valid[t]` and `redir_pc[t]` (the expected next PC) appear in the same cycle, and younger tokens of that thread are not sent. The buffer and that cycle's accepted group are discarded, and the thread is StartSquash (code 2) next cycle.
- R8: A commit squash `csq[t]` wins over stalls and mispredicts. It sends nothing for the thread and raises no redirect, block or unblock. It discards the buffer and the accepted group, drives `sq_cnt[t]` with the number of tokens discarded (it is 0 without a squash), and makes the thread Squashing (code 3) next cycle.
- R9: A group accepted while the thread is StartSquash or Squashing is discarded.
- R10: A thread not covered by R4, R5, R7 or R8 becomes Running if its buffer is non-empty at the end of the cycle and Idle otherwise. `stage_active` is 1 whenever any thread is not Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_valid | input | 2 | Per-thread group valid from fetch |
| fe_ready | output | 2 | Per-thread room for a full group |
| fe_cnt | input | 2*NW | Per-thread lane count, 1..W |
| fe_tok | input | 2*W*TW | Lane tokens, thread-major, lane t*W+l |
| stall_src | input | 6 | Per thread: rename, issue/execute, commit stall bits |
| csq | input | 2 | Per-thread squash from commit |
| sq_cnt | output | 2*CW | Tokens discarded by the commit squash |
| rn_valid | output | W | Output slot valid to rename |
| rn_tid | output | W | Thread of each output slot |
| rn_tok | output | W*TW | Token of each output slot |
| redir_valid | output | 2 | Fetch redirect request per thread |
| redir_pc | output | 2*PCW | Corrected fetch PC per thread |
| fe_block | output | 2 | Pulse: thread has just blocked |
| fe_unblock | output | 2 | Pulse: thread has drained and unblocked |
| thr_state | output | 6 | Per-thread status code, 3 bits each |
| stage_active | output | 1 | Some thread is not Idle |

## Verification
The hardest case to reach from the ports is a thread leaving a long stall with a full skid buffer while the other thread keeps competing for slots, ideally with a mispredicted token somewhere in the draining group. The stimulus holds one thread's stall bits high for windows of about twenty cycles while fetch keeps offering groups. That fills the buffer to the ready threshold, and the drain then passes through Unblocking under alternating priority. Later phases add wrong predictions and sparse commit squashes on top of that traffic. A behavioural queue model predicts every slot, redirect, pulse and status code in every cycle.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int NT = 2;
  localparam int NSTALL = 3;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_SSQ  = 3'd2,
    ST_SQ   = 3'd3,
    ST_BLK  = 3'd4,
    ST_UNB  = 3'd5
  } thr_st_e;
endpackage

// File: rtl/dec_skid.sv
module dec_skid #(
  parameter int W = 2,
  parameter int TW = 49,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [NW-1:0]   push_n,
  input  logic [W*TW-1:0] push_d,
  input  logic [NW-1:0]   pop_n,
  output logic [CW-1:0]   occ,
  output logic [W*TW-1:0] head_d
);
  logic [TW-1:0] mem [DEPTH];
  logic [AW-1:0] rd, wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd  <= '0;
      wr  <= '0;
      occ <= '0;
    end else if (flush) begin
      rd  <= wr;
      occ <= '0;
    end else begin
      rd  <= rd + AW'(pop_n);
      wr  <= wr + AW'(push_n);
      occ <= occ + CW'(push_n) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < W; i++) begin
      if (!flush && NW'(i) < push_n) mem[wr + AW'(i)] <= push_d[i*TW +: TW];
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_head
    assign head_d[g*TW +: TW] = mem[rd + AW'(g)];
  end
endmodule

// File: rtl/dec_brchk.sv
module dec_brchk #(
  parameter int W = 2,
  parameter int PCW = 16,
  parameter int ISZ = 4,
  localparam int TW = 3 * PCW + 1,
  localparam int NW = $clog2(W + 1)
) (
  input  logic [W*TW-1:0] head_d,
  input  logic [NW-1:0]   take_n,
  output logic [NW-1:0]   keep_n,
  output logic            misp,
  output logic [PCW-1:0]  fix_pc
);
  logic [TW-1:0]  tk;
  logic [PCW-1:0] want;

  // scan from the youngest candidate down so the oldest mismatch wins
  always_comb begin
    keep_n = take_n;
    misp   = 1'b0;
    fix_pc = '0;
    tk     = '0;
    want   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      tk   = head_d[i*TW +: TW];
      want = tk[3*PCW] ? tk[3*PCW-1:2*PCW] : tk[PCW-1:0] + PCW'(ISZ);
      if (NW'(i) < take_n && want != tk[2*PCW-1:PCW]) begin
        misp   = 1'b1;
        fix_pc = want;
        keep_n = NW'(i + 1);
      end
    end
  end
endmodule

// File: rtl/dec_thr.sv
module dec_thr
  import dec_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csq,
  input  logic          misp,
  input  logic          stall,
  input  logic [CW-1:0] occ_nx,
  output thr_st_e       st,
  output logic          blk_p,
  output logic          unblk_p
);
  thr_st_e nx;
  logic    held;

  assign held = (st == ST_BLK) || (st == ST_UNB);

  always_comb begin
    if (csq)        nx = ST_SQ;
    else if (misp)  nx = ST_SSQ;
    else if (stall) nx = ST_BLK;
    else if (held)  nx = (occ_nx == '0) ? ST_RUN : ST_UNB;
    else            nx = (occ_nx != '0) ? ST_RUN : ST_IDLE;
  end

  assign blk_p   = (nx == ST_BLK) && (st != ST_BLK);
  assign unblk_p = held && (nx == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nx;
  end
endmodule

// File: rtl/dec_stage.sv
module dec_stage
  import dec_pkg::*;
#(
  parameter int W = 2,
  parameter int PCW = 16,
  parameter int DEPTH = 4,
  parameter int ISZ = 4,
  localparam int TW = 3 * PCW + 1,
  localparam int NW = $clog2(W + 1),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NT-1:0]      fe_valid,
  output logic [NT-1:0]      fe_ready,
  input  logic [NT*NW-1:0]   fe_cnt,
  input  logic [NT*W*TW-1:0] fe_tok,
  input  logic [NT*3-1:0]    stall_src,
  input  logic [NT-1:0]      csq,
  output logic [NT*CW-1:0]   sq_cnt,
  output logic [W-1:0]       rn_valid,
  output logic [W-1:0]       rn_tid,
  output logic [W*TW-1:0]    rn_tok,
  output logic [NT-1:0]      redir_valid,
  output logic [NT*PCW-1:0]  redir_pc,
  output logic [NT-1:0]      fe_block,
  output logic [NT-1:0]      fe_unblock,
  output logic [NT*3-1:0]    thr_state,
  output logic               stage_active
);
  logic [CW-1:0]   occ    [NT];
  logic [W*TW-1:0] head   [NT];
  logic [NW-1:0]   take   [NT];
  logic [NW-1:0]   keep   [NT];
  logic [NT-1:0]   elig, misp;
  logic            prio;
  int              nf, ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio <= 1'b0;
    else        prio <= ~prio;
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    thr_st_e       st;
    logic          acc, stall, sqst;
    logic [NW-1:0] push_n;
    logic [CW-1:0] occ_nx;

    assign stall       = |stall_src[t*NSTALL +: NSTALL];
    assign fe_ready[t] = occ[t] <= CW'(DEPTH - W);
    assign acc         = fe_valid[t] && fe_ready[t];
    assign sqst        = (st == ST_SSQ) || (st == ST_SQ);
    assign push_n      = (acc && !sqst && !csq[t]) ? fe_cnt[t*NW +: NW] : '0;
    assign elig[t]     = !stall && !csq[t] && (occ[t] != '0);
    assign occ_nx      = (csq[t] || misp[t]) ? '0 : occ[t] - CW'(keep[t]) + CW'(push_n);
    assign sq_cnt[t*CW +: CW] = csq[t] ? occ[t] + (acc ? CW'(fe_cnt[t*NW +: NW]) : '0) : '0;
    assign redir_valid[t] = misp[t];
    assign thr_state[t*3 +: 3] = st;

    dec_skid #(.W(W), .TW(TW), .DEPTH(DEPTH)) u_skid (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (csq[t] || misp[t]),
      .push_n(push_n),
      .push_d(fe_tok[t*W*TW +: W*TW]),
      .pop_n (keep[t]),
      .occ   (occ[t]),
      .head_d(head[t])
    );

    dec_brchk #(.W(W), .PCW(PCW), .ISZ(ISZ)) u_chk (
      .head_d(head[t]),
      .take_n(take[t]),
      .keep_n(keep[t]),
      .misp  (misp[t]),
      .fix_pc(redir_pc[t*PCW +: PCW])
    );

    dec_thr #(.DEPTH(DEPTH)) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .csq    (csq[t]),
      .misp   (misp[t]),
      .stall  (stall),
      .occ_nx (occ_nx),
      .st     (st),
      .blk_p  (fe_block[t]),
      .unblk_p(fe_unblock[t])
    );
  end

  // slot budget: priority thread first, the other fills what is left
  always_comb begin
    int of, os;
    of = int'(occ[prio]);
    os = int'(occ[~prio]);
    nf = elig[prio]  ? ((of < W) ? of : W) : 0;
    ns = elig[~prio] ? ((os < W - nf) ? os : W - nf) : 0;
  end

  assign take[0] = prio ? NW'(ns) : NW'(nf);
  assign take[1] = prio ? NW'(nf) : NW'(ns);

  always_comb begin
    rn_valid = '0;
    rn_tid   = '0;
    rn_tok   = '0;
    for (int i = 0; i < W; i++) begin
      if (i < nf) begin
        rn_tid[i]          = prio;
        rn_tok[i*TW +: TW] = head[prio][i*TW +: TW];
        rn_valid[i]        = i < int'(keep[prio]);
      end else if (i < nf + ns) begin
        rn_tid[i]          = ~prio;
        rn_tok[i*TW +: TW] = head[~prio][(i-nf)*TW +: TW];
        rn_valid[i]        = (i - nf) < int'(keep[~prio]);
      end
    end
  end

  assign stage_active = (thr_state[2:0] != 3'd0) || (thr_state[5:3] != 3'd0);
endmodule

// File: rtl/dec_stage_chk.sv
module dec_stage_chk #(
  parameter int W = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   csq,
  input logic [5:0]   stall_src,
  input logic [W-1:0] rn_valid,
  input logic [W-1:0] rn_tid,
  input logic [1:0]   redir_valid,
  input logic [1:0]   fe_block,
  input logic [1:0]   fe_unblock,
  input logic [5:0]   thr_state
);
  for (genvar t = 0; t < 2; t++) begin : g_t
    logic [W-1:0] own;
    assign own = (t == 1) ? rn_tid : ~rn_tid;

    // R4
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|stall_src[t*3 +: 3]) |-> !(|(rn_valid & own)));
    // R4
    block_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fe_block[t] |=> (thr_state[t*3 +: 3] == 3'd4));
    // R5
    unblock_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fe_unblock[t] |=> (thr_state[t*3 +: 3] == 3'd1));
    // R7
    redir_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid[t] |=> (thr_state[t*3 +: 3] == 3'd2));
    // R8
    csq_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csq[t] |=> (thr_state[t*3 +: 3] == 3'd3));
    // R8
    csq_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csq[t] |-> !redir_valid[t] && !fe_block[t] && !fe_unblock[t] && !(|(rn_valid & own)));
  end
endmodule

bind dec_stage dec_stage_chk #(.W(W)) u_chk_bind (.*);

// File: tb/dec_stage_tb.sv
module dec_stage_tb;
  localparam int W = 2;
  localparam int PCW = 16;
  localparam int DEPTH = 4;
  localparam int ISZ = 4;
  localparam int TW = 3 * PCW + 1;
  localparam int NW = $clog2(W + 1);
  localparam int CW = $clog2(DEPTH + 1);

  typedef logic [TW-1:0] tok_t;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [1:0]         fe_valid = '0;
  logic [1:0]         fe_ready;
  logic [2*NW-1:0]    fe_cnt = '0;
  logic [2*W*TW-1:0]  fe_tok = '0;
  logic [5:0]         stall_src = '0;
  logic [1:0]         csq = '0;
  logic [2*CW-1:0]    sq_cnt;
  logic [W-1:0]       rn_valid, rn_tid;
  logic [W*TW-1:0]    rn_tok;
  logic [1:0]         redir_valid;
  logic [2*PCW-1:0]   redir_pc;
  logic [1:0]         fe_block, fe_unblock;
  logic [5:0]         thr_state;
  logic               stage_active;

  dec_stage #(.W(W), .PCW(PCW), .DEPTH(DEPTH), .ISZ(ISZ)) u_dut (.*);

  always #2.5 clk = ~clk;

  int   nchk = 0, nfail = 0, cyc = 0;
  tok_t mq [2][$];
  int   mst [2];
  int   mprio;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  function automatic tok_t mk_tok(input int mp);
    logic [PCW-1:0] pc, tg, pn;
    logic br;
    int r;
    pc = PCW'($urandom) & ~PCW'(3);
    tg = PCW'($urandom) & ~PCW'(3);
    r  = int'($urandom % 100);
    if (r < mp) begin
      if (r % 2 == 0) begin br = 1'b1; pn = tg ^ PCW'(16); end
      else begin br = 1'b0; pn = pc + PCW'(2 * ISZ); end
    end else if (r % 3 == 0) begin
      br = 1'b1; pn = tg;
    end else begin
      br = 1'b0; pn = pc + PCW'(ISZ);
    end
    return {br, tg, pn, pc};
  endfunction

  task automatic drive(input int phase);
    int mp;
    mp = (phase >= 2) ? 15 : 0;
    for (int t = 0; t < 2; t++) begin
      fe_valid[t] = ($urandom % 100) < 75;
      fe_cnt[t*NW +: NW] = NW'(1 + $urandom % W);
      for (int l = 0; l < W; l++) fe_tok[(t*W+l)*TW +: TW] = mk_tok(mp);
      csq[t] = (phase >= 3) && (($urandom % 100) < 4);
    end
    case (phase)
      0: stall_src = '0;
      1: begin
        stall_src[2:0] = ((cyc / 20) % 2 == 1) ? 3'(1 << ($urandom % 3)) : 3'd0;
        stall_src[5:3] = (($urandom % 100) < 10) ? 3'(1 << ($urandom % 3)) : 3'd0;
      end
      default: begin
        stall_src[2:0] = (($urandom % 100) < 15) ? 3'(1 << ($urandom % 3)) : 3'd0;
        stall_src[5:3] = ((cyc / 25) % 3 == 2) ? 3'(1 << ($urandom % 3)) : 3'd0;
      end
    endcase
  endtask

  // compare outputs against the queue model, then advance the model one clock
  task automatic step();
    int occ[2], cnt[2], nt[2], kept[2], nocc[2], nst[2], slot_t[W], slot_j[W];
    bit acc[2], stl[2], el[2], mis[2], sqs[2];
    logic [PCW-1:0] fix[2], want;
    tok_t tk;
    int f, s, nf, ns, scnt;
    for (int t = 0; t < 2; t++) begin
      occ[t] = mq[t].size();
      cnt[t] = int'(fe_cnt[t*NW +: NW]);
      acc[t] = fe_valid[t] && (occ[t] <= DEPTH - W);
      stl[t] = |stall_src[t*3 +: 3];
      el[t]  = !stl[t] && !csq[t] && occ[t] > 0;
      sqs[t] = (mst[t] == 2) || (mst[t] == 3);
    end
    f = mprio; s = 1 - mprio;
    nf = el[f] ? ((occ[f] < W) ? occ[f] : W) : 0;
    ns = el[s] ? ((occ[s] < W - nf) ? occ[s] : W - nf) : 0;
    nt[f] = nf; nt[s] = ns;
    for (int t = 0; t < 2; t++) begin
      mis[t] = 0; kept[t] = nt[t]; fix[t] = '0;
      for (int j = 0; j < nt[t] && !mis[t]; j++) begin
        tk = mq[t][j];
        want = tk[3*PCW] ? tk[3*PCW-1:2*PCW] : tk[PCW-1:0] + PCW'(ISZ);
        if (want != tk[2*PCW-1:PCW]) begin mis[t] = 1; fix[t] = want; kept[t] = j + 1; end
      end
    end
    // R6 R3 R7: slot contents
    for (int i = 0; i < W; i++) begin
      if (i < nf) begin slot_t[i] = f; slot_j[i] = i; end
      else if (i < nf + ns) begin slot_t[i] = s; slot_j[i] = i - nf; end
      else begin slot_t[i] = -1; slot_j[i] = 0; end
      if (slot_t[i] >= 0 && slot_j[i] < kept[slot_t[i]]) begin
        chk("R6", "slot valid", rn_valid[i], 1);
        chk("R6", "slot thread", rn_tid[i], slot_t[i]);
        chk("R3", "slot token", rn_tok[i*TW +: TW], mq[slot_t[i]][slot_j[i]]);
      end else begin
        chk("R7", "slot idle", rn_valid[i], 0);
      end
    end
    for (int t = 0; t < 2; t++) begin
      chk("R2", "fe_ready", fe_ready[t], occ[t] <= DEPTH - W);
      chk("R7", "redir_valid", redir_valid[t], mis[t]);
      if (mis[t]) chk("R7", "redir_pc", redir_pc[t*PCW +: PCW], fix[t]);
      scnt = csq[t] ? occ[t] + (acc[t] ? cnt[t] : 0) : 0;
      chk("R8", "sq_cnt", sq_cnt[t*CW +: CW], scnt);
      chk("R10", "state", thr_state[t*3 +: 3], mst[t]);
      if (csq[t] || mis[t]) nocc[t] = 0;
      else nocc[t] = occ[t] - kept[t] + ((acc[t] && !sqs[t]) ? cnt[t] : 0);
      if (csq[t]) nst[t] = 3;
      else if (mis[t]) nst[t] = 2;
      else if (stl[t]) nst[t] = 4;
      else if (mst[t] == 4 || mst[t] == 5) nst[t] = (nocc[t] == 0) ? 1 : 5;
      else nst[t] = (nocc[t] != 0) ? 1 : 0;
      chk("R4", "fe_block", fe_block[t], (nst[t] == 4) && (mst[t] != 4));
      chk("R5", "fe_unblock", fe_unblock[t], (mst[t] == 4 || mst[t] == 5) && nst[t] == 1);
    end
    chk("R10", "stage_active", stage_active, (mst[0] != 0) || (mst[1] != 0));
    // advance model
    for (int t = 0; t < 2; t++) begin
      if (csq[t] || mis[t]) mq[t].delete();
      else begin
        for (int k = 0; k < kept[t]; k++) void'(mq[t].pop_front());
        if (acc[t] && !sqs[t])
          for (int l = 0; l < cnt[t]; l++) mq[t].push_back(fe_tok[(t*W+l)*TW +: TW]);
      end
      mst[t] = nst[t];
    end
    mprio = 1 - mprio;
    cyc++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    mst[0] = 0; mst[1] = 0; mprio = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "thread0 state", thr_state[2:0], 0);
    chk("R1", "thread1 state", thr_state[5:3], 0);
    chk("R1", "stage_active", stage_active, 0);
    chk("R1", "rn_valid", rn_valid, 0);
    chk("R1", "fe_ready", fe_ready, 2'b11);
    step();
    for (int ph = 0; ph < 4; ph++) begin
      for (int n = 0; n < 400; n++) begin
        @(negedge clk);
        drive(ph);
        #1;
        step();
      end
    end
    // R9: squash of thread 1 followed by a group offered in the Squashing cycle
    @(negedge clk);
    fe_valid = 2'b10; stall_src = '0; csq = 2'b10;
    fe_cnt[NW +: NW] = NW'(W);
    #1; step();
    @(negedge clk);
    csq = '0; fe_valid = 2'b10;
    #1; step();
    @(negedge clk);
    fe_valid = '0;
    #1; step();
    chk("R9", "buffer empty after squash-state group", rn_valid, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule